// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a single timer channel that turns a rising edge on its gate input into a low-going output pulse. The pulse lasts a programmed number of counting-clock cycles. Software first issues a control write, which parks the output high and disarms the channel. It then issues a count write, which stores a 16-bit length value and arms the channel. From then on, every rising edge of the gate loads the length into a separate down-counter and drives the output low. The output returns high when that counter reaches zero.

The pulse can be retriggered. An edge that arrives while the output is low restarts the full length from that edge. A length written while a pulse is running is only held in the count register, and the next trigger picks it up. The down-counter never stops: once it reaches zero it keeps counting down and wraps. The current counter value is exposed so it can be observed. The level of the gate has no effect; only its low-to-high transition matters. A stored length of zero produces a pulse of 65536 cycles.

Top module: `oneshot_timer`

## Requirements
- R1: While the synchronous reset `rst` is high, the output `pulse_n` is high, the counter value `cnt_o` is 0 and the channel is disarmed.
- R2: A write with `wr_ctrl`=1 drives `pulse_n` high at the next clock edge, even during a pulse, and disarms the channel. After it, gate edges are ignored until a count write arrives.
- R3: A write with `wr_ctrl`=0 stores `wr_data` as the pulse length and arms the channel. It neither loads the counter nor changes `pulse_n`, and the counter keeps decrementing by one per clock.
- R4: When the gate is sampled high on a clock edge after being sampled low at the edge before, and the channel is armed, that same edge loads the stored length into the counter and drives `pulse_n` low.
- R5: After a load with length N (1..65535), `pulse_n` stays low for exactly N clock cycles and goes high on the edge where the counter reaches 0.
- R6: A trigger that arrives while `pulse_n` is low reloads the counter, so that `pulse_n` stays low until N cycles after the most recent trigger.
- R7: Further triggers fire further pulses of the same length without the count being rewritten.
- R8: A count write during a pulse does not shorten or lengthen that pulse. The new length is used from the next trigger onward.
- R9: Without a load, the counter decrements every clock and wraps from 0x0000 to 0xFFFF, and `pulse_n` stays high while it does.
- R10: The gate level has no effect. Holding the gate high does not retrigger, and only a low-to-high transition starts or restarts a pulse.
- R11: A stored length of 0 produces a low pulse of 65536 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Programming strobe, one cycle per write |
| wr_ctrl | input | 1 | 1: control write, 0: count write |
| wr_data | input | 16 | Pulse length for a count write |
| gate | input | 1 | Trigger input; a rising edge fires the pulse |
| pulse_n | output | 1 | One-shot output, low during the pulse |
| cnt_o | output | 16 | Current value of the down-counter |

## Verification
The hardest situations to reach from the ports are the ones where two timelines overlap. One is a retrigger in the middle of a pulse. The other is a new count written while the old pulse is still running. The stimulus table places a second gate edge a chosen number of cycles into each pulse and checks the total low time. Directed steps write a shorter length one cycle into a long pulse and then check that only the following trigger uses it. The 65536-cycle pulse for a zero length, and the counter wrapping through zero, are reached by letting the counter run its full span.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;
   typedef enum logic {
      WR_KIND_COUNT = 1'b0,
      WR_KIND_CTRL  = 1'b1
   } wr_kind_e;

   typedef struct packed {
      logic     stb;
      wr_kind_e kind;
   } wr_cmd_t;
endpackage

// File: rtl/oneshot_gate_edge.sv
module oneshot_gate_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic gate,
   output logic rise
);
   logic gate_s;
   logic gate_prev;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign gate_s = gate;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], gate} & {SYNC_STAGES{1'b1}};
         end
         assign gate_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) gate_prev <= 1'b0;
      else     gate_prev <= gate_s;
   end

   assign rise = gate_s & ~gate_prev;

   p_single_rise_r10: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/oneshot_count_reg.sv
module oneshot_count_reg
   import oneshot_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  wr_cmd_t          cmd,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_q,
   output logic             armed_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
         armed_q <= 1'b0;
      end else if (cmd.stb) begin
         if (cmd.kind == WR_KIND_CTRL) begin
            armed_q <= 1'b0;
         end else begin
            count_q <= wr_data;
            armed_q <= 1'b1;
         end
      end
   end

   p_arm_on_count_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd.stb && cmd.kind == WR_KIND_COUNT) |=> (armed_q && count_q == $past(wr_data)));
   p_disarm_on_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd.stb && cmd.kind == WR_KIND_CTRL) |=> !armed_q);
endmodule

// File: rtl/oneshot_down_cnt.sv
module oneshot_down_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             at_one
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else           cnt_q <= cnt_q - ONE;
   end

   assign at_one = (cnt_q == ONE);
endmodule

// File: rtl/oneshot_out_ctl.sv
module oneshot_out_ctl (
   input  logic clk,
   input  logic rst,
   input  logic ctrl_wr,
   input  logic load,
   input  logic at_one,
   output logic out_q
);
   always_ff @(posedge clk) begin
      if (rst)                 out_q <= 1'b1;
      else if (ctrl_wr)        out_q <= 1'b1;
      else if (load)           out_q <= 1'b0;
      else if (!out_q && at_one) out_q <= 1'b1;
   end

   p_low_needs_load_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(out_q) |-> $past(load));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
   import oneshot_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_stb,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             gate,
   output logic             pulse_n,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
   endgenerate

   wr_cmd_t          cmd;
   logic             rise;
   logic             armed;
   logic [CNT_W-1:0] count_val;
   logic             load;
   logic             ctrl_wr;
   logic             at_one;

   assign cmd.stb  = wr_stb;
   assign cmd.kind = wr_ctrl ? WR_KIND_CTRL : WR_KIND_COUNT;
   assign ctrl_wr  = wr_stb & wr_ctrl;
   assign load     = rise & armed & ~ctrl_wr;

   oneshot_gate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk (clk), .rst (rst), .gate (gate), .rise (rise)
   );

   oneshot_count_reg #(.CNT_W(CNT_W)) u_creg (
      .clk (clk), .rst (rst), .cmd (cmd), .wr_data (wr_data),
      .count_q (count_val), .armed_q (armed)
   );

   oneshot_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk), .rst (rst), .load (load), .load_val (count_val),
      .cnt_q (cnt_o), .at_one (at_one)
   );

   oneshot_out_ctl u_out (
      .clk (clk), .rst (rst), .ctrl_wr (ctrl_wr), .load (load),
      .at_one (at_one), .out_q (pulse_n)
   );

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (pulse_n && cnt_o == '0));
   p_ctrl_high_r2: assert property (@(posedge clk) disable iff (rst)
      ctrl_wr |=> pulse_n);
   p_count_wr_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !wr_ctrl && pulse_n && !load) |=> pulse_n);
   p_load_r4: assert property (@(posedge clk) disable iff (rst)
      load |=> (!pulse_n && cnt_o == $past(count_val)));
   p_end_r5: assert property (@(posedge clk) disable iff (rst)
      (!pulse_n && cnt_o == CNT_W'(1) && !load && !ctrl_wr) |=> (pulse_n && cnt_o == '0));
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!pulse_n && cnt_o != CNT_W'(1) && !ctrl_wr) |=> !pulse_n);
   p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
      (pulse_n && cnt_o == '0 && !load) |=> (pulse_n && cnt_o == ALL_ONES));
endmodule

// File: tb/oneshot_timer_tb_top.sv
module oneshot_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_stb = 1'b0;
   logic        wr_ctrl = 1'b0;
   logic [15:0] wr_data = '0;
   logic        gate = 1'b0;
   logic        pulse_n;
   logic [15:0] cnt_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   oneshot_timer dut_i (
      .clk (clk), .rst (rst), .wr_stb (wr_stb), .wr_ctrl (wr_ctrl),
      .wr_data (wr_data), .gate (gate), .pulse_n (pulse_n), .cnt_o (cnt_o)
   );

   typedef struct packed {
      logic [15:0] len;
      logic [15:0] gap;
      logic [31:0] exp_low;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'd3,  16'd0, 32'd3},
      '{16'd1,  16'd0, 32'd1},
      '{16'd5,  16'd2, 32'd8},
      '{16'd4,  16'd3, 32'd8},
      '{16'd10, 16'd0, 32'd10},
      '{16'd2,  16'd0, 32'd2},
      '{16'd7,  16'd5, 32'd13}
   };

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic ctrl, input logic [15:0] d);
      wr_stb = 1'b1; wr_ctrl = ctrl; wr_data = d;
      tick();
      wr_stb = 1'b0; wr_ctrl = 1'b0;
   endtask

   task automatic trig();
      gate = 1'b1;
      tick();
      gate = 1'b0;
   endtask

   task automatic measure(output int n);
      n = 0;
      while (!pulse_n && n < 70000) begin
         n++;
         tick();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int low;
      logic [15:0] prev;
      repeat (3) tick();
      // R1: reset state
      chk(pulse_n == 1'b1, "R1 out", pulse_n, 1);
      chk(cnt_o == 16'd0, "R1 cnt", cnt_o, 0);
      rst = 1'b0;
      tick();
      // R2: not armed after reset, edge ignored
      trig();
      chk(pulse_n == 1'b1, "R2 unarmed trigger", pulse_n, 1);

      // R4 R5 R6 R3: table walk
      for (int v = 0; v < NV; v++) begin
         wr(1'b1, 16'd0);
         wr(1'b0, VECS[v].len);
         chk(pulse_n == 1'b1, "R3 out after count write", pulse_n, 1);
         trig();
         chk(pulse_n == 1'b0, "R4 out low after trigger", pulse_n, 0);
         chk(cnt_o == VECS[v].len, "R4 load value", cnt_o, VECS[v].len);
         if (VECS[v].gap == 16'd0) begin
            measure(n);
            chk(n == int'(VECS[v].exp_low), "R5 pulse length", n, VECS[v].exp_low);
         end else begin
            low = 0;
            for (int i = 0; i <= int'(VECS[v].gap); i++) begin
               if (!pulse_n) low++;
               if (i < int'(VECS[v].gap)) tick();
            end
            trig();
            measure(n);
            chk(low + n == int'(VECS[v].exp_low), "R6 retriggered length", low + n, VECS[v].exp_low);
         end
      end

      // R3: count write does not load the counter
      wr(1'b1, 16'd0);
      prev = cnt_o;
      wr(1'b0, 16'h0050);
      chk(cnt_o == prev - 16'd1, "R3 counter keeps decrementing", cnt_o, prev - 16'd1);

      // R7: repeat pulses without rewrite
      for (int k = 0; k < 3; k++) begin
         trig();
         measure(n);
         chk(n == 16'h0050, "R7 repeated pulse", n, 16'h0050);
      end

      // R9: wrap after zero
      wr(1'b0, 16'd2);
      trig();
      measure(n);
      chk(cnt_o == 16'd0 && pulse_n, "R9 zero at end", cnt_o, 0);
      tick();
      chk(cnt_o == 16'hFFFF, "R9 wrap value", cnt_o, 16'hFFFF);
      chk(pulse_n == 1'b1, "R9 out high on wrap", pulse_n, 1);

      // R10: gate level has no effect
      wr(1'b0, 16'd3);
      gate = 1'b1;
      repeat (10) tick();
      chk(pulse_n == 1'b1, "R10 held gate no retrigger", pulse_n, 1);
      gate = 1'b0;
      tick();
      chk(pulse_n == 1'b1, "R10 gate fall no effect", pulse_n, 1);
      trig();
      chk(pulse_n == 1'b0, "R10 new rising edge fires", pulse_n, 0);
      measure(n);

      // R8: count write mid-pulse
      wr(1'b0, 16'd6);
      trig();
      wr(1'b0, 16'd2);
      measure(n);
      chk(n + 1 == 6, "R8 running pulse unchanged", n + 1, 6);
      trig();
      measure(n);
      chk(n == 2, "R8 next trigger uses new count", n, 2);

      // R2: control write ends pulse and disarms
      wr(1'b0, 16'd9);
      trig();
      tick(); tick();
      wr(1'b1, 16'd0);
      chk(pulse_n == 1'b1, "R2 control write forces high", pulse_n, 1);
      trig();
      chk(pulse_n == 1'b1, "R2 disarmed after control write", pulse_n, 1);

      // R11: zero length gives 65536 cycles
      wr(1'b0, 16'd0);
      trig();
      measure(n);
      chk(n == 65536, "R11 zero length", n, 65536);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule